// File: doc/BRIEF.md
# DMA Fixed-Priority Channel Arbiter

This block decides which DMA channel the transfer engine serves next. Each of the channels has a request line and a programmable priority level. While the engine is idle, the arbiter takes all active requests and grants the one with the highest level. If several requesting channels share the winning level, the lowest-numbered of them is granted. The grant is a channel index with a valid bit. It stays fixed until the engine reports that the transfer is done.

At every grant the arbiter also checks two kinds of error. The first is a global priority conflict: two or more channels have the same level. Even with a conflict, arbitration goes ahead using the tie-break. The second is a descriptor error reported for the selected channel. Either error is recorded against the granted channel in a small status register. That register holds a valid bit, the channel number and a priority-conflict bit. Software clears it with a write-one-to-clear pulse, and an interrupt stays high while an error is held. The engine, the descriptor storage and round-robin mode are outside this block.

Top module: `dma_prio_arbiter`

## Requirements
- R1: One clock edge after the arbiter is idle (`gnt_valid` low) with any `req` bit set, `gnt_valid` is 1. `gnt_ch` then holds the requesting channel whose level is numerically largest. Channel i's level is `prio[i*PW +: PW]`.
- R2: When several requesting channels share the largest level, `gnt_ch` is the lowest index among them.
- R3: While no request is active, no grant is issued. No error is recorded in that time, even if priority levels are duplicated.
- R4: If any two channels hold equal levels at a grant edge, the grant is still issued as in R1/R2. After that edge, `err_valid`=1, `err_prio`=1, and `err_ch` equals the granted channel.
- R5: While `gnt_valid` is 1, `gnt_ch` and `gnt_valid` hold until `eng_done` is sampled high. Changes to `req` or `prio` do not affect them. One edge after `eng_done`, `gnt_valid` is 0.
- R6: If `desc_bad` of the selected channel is high at its grant edge, then after that edge `err_valid`=1 and `err_ch`=that channel. `err_prio` is unchanged when the levels are unique.
- R7: A descriptor error that is not removed is recorded again at the channel's next grant, even after it has been cleared.
- R8: An `err_clr` pulse clears `err_valid` and `err_prio` at the next edge. If a new error is recorded at the same edge, the new error wins.
- R9: `err_irq` is high exactly while `err_valid` is 1.
- R10: After reset, `gnt_valid`, `err_valid`, `err_prio` and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NCH | Per-channel service request |
| prio | input | NCH*PW | Packed priority levels, channel i at bits i*PW +: PW |
| desc_bad | input | NCH | Per-channel descriptor inconsistency flag |
| eng_done | input | 1 | Engine finished the granted transfer |
| err_clr | input | 1 | Write-one-to-clear pulse for error status |
| gnt_valid | output | 1 | Grant is active |
| gnt_ch | output | $clog2(NCH) | Granted channel index |
| err_valid | output | 1 | Error status holds an error |
| err_ch | output | $clog2(NCH) | Channel the recorded error belongs to |
| err_prio | output | 1 | Duplicate priority levels were seen |
| err_irq | output | 1 | Error interrupt |

## Verification
The selection is tried with three kinds of level assignment:
- Ascending unique levels, where the highest channel number wins.
- Reversed unique levels, where the lowest channel number wins. Telling these two apart exposes comparisons that are inverted or depend on position.
- A shared top level, which separates the lowest-index tie-break from highest-index selection and also triggers the conflict flag.

Changing `req` and `prio` mid-grant shows whether the grant really holds. A cleared and then repeated descriptor error shows whether the error is detected again. Clearing in the same cycle as a new error shows which of the two wins.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH = 16,
  parameter int PW  = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  input  logic [NCH-1:0]    desc_bad,
  input  logic              eng_done,
  input  logic              err_clr,
  output logic              gnt_valid,
  output logic [CW-1:0]     gnt_ch,
  output logic              err_valid,
  output logic [CW-1:0]     err_ch,
  output logic              err_prio,
  output logic              err_irq
);

  logic          found;
  logic [PW-1:0] best;
  logic [CW-1:0] win;
  logic          dup;
  logic          arb_fire;
  logic          new_err;

  always_comb begin
    found = 1'b0;
    best  = '0;
    win   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req[i] && (!found || prio[i*PW +: PW] > best)) begin
        found = 1'b1;
        best  = prio[i*PW +: PW];
        win   = CW'(i);
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NCH; i++)
      for (int j = i + 1; j < NCH; j++)
        if (prio[i*PW +: PW] == prio[j*PW +: PW]) dup = 1'b1;
  end

  assign arb_fire = !gnt_valid && found;
  assign new_err  = arb_fire && (dup || desc_bad[win]);
  assign err_irq  = err_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_ch    <= '0;
    end else if (arb_fire) begin
      gnt_valid <= 1'b1;
      gnt_ch    <= win;
    end else if (gnt_valid && eng_done) begin
      gnt_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_ch    <= '0;
      err_prio  <= 1'b0;
    end else if (new_err) begin
      err_valid <= 1'b1;
      err_ch    <= win;
      err_prio  <= (err_prio && !err_clr) || dup;
    end else if (err_clr) begin
      err_valid <= 1'b0;
      err_prio  <= 1'b0;
    end
  end

  AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && |req) |=> gnt_valid); // R1
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !eng_done) |=> (gnt_valid && $stable(gnt_ch))); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && eng_done) |=> !gnt_valid); // R5
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && req == '0) |=> !gnt_valid); // R3
  AST_PRIO_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    err_prio |-> err_valid); // R4
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !new_err) |=> (!err_valid && !err_prio)); // R8

endmodule

// File: tb/tb_dma_prio_arbiter.sv
`timescale 1ns/1ps
module tb_dma_prio_arbiter;
  localparam int NCH = 16;
  localparam int PW  = 4;
  localparam int CW  = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] req = '0;
  logic [PW-1:0] lvl [NCH];
  logic [NCH*PW-1:0] prio;
  logic [NCH-1:0] desc_bad = '0;
  logic eng_done = 1'b0;
  logic err_clr = 1'b0;
  logic gnt_valid, err_valid, err_prio, err_irq;
  logic [CW-1:0] gnt_ch, err_ch;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) prio[i*PW +: PW] = lvl[i];

  dma_prio_arbiter #(.NCH(NCH), .PW(PW)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .desc_bad(desc_bad),
    .eng_done(eng_done), .err_clr(err_clr), .gnt_valid(gnt_valid),
    .gnt_ch(gnt_ch), .err_valid(err_valid), .err_ch(err_ch),
    .err_prio(err_prio), .err_irq(err_irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic levels_up();
    for (int i = 0; i < NCH; i++) lvl[i] = PW'(i);
  endtask

  task automatic levels_down();
    for (int i = 0; i < NCH; i++) lvl[i] = PW'(NCH - 1 - i);
  endtask

  task automatic grant(input logic [NCH-1:0] r);
    req = r;
    @(negedge clk);
  endtask

  task automatic release_gnt();
    eng_done = 1'b1;
    req = '0;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic clear_err();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 gnt_valid", gnt_valid, 0);
    chk("R10 err_valid", err_valid, 0);
    chk("R10 err_prio", err_prio, 0);
    chk("R10 err_irq", err_irq, 0);
  endtask

  task automatic t_highest();
    levels_up();
    grant(16'h0088);
    chk("R1 valid up", gnt_valid, 1);
    chk("R1 ch up", gnt_ch, 7);
    chk("R6 no err unique", err_valid, 0);
    release_gnt();
    chk("R5 released", gnt_valid, 0);
    levels_down();
    grant(16'h1020);
    chk("R1 ch down", gnt_ch, 5);
    release_gnt();
  endtask

  task automatic t_tie();
    levels_up();
    lvl[4] = 4'd15;
    lvl[10] = 4'd15;
    grant(16'h0410);
    chk("R2 tie low index", gnt_ch, 4);
    chk("R4 prio flag", err_prio, 1);
    chk("R4 err ch", err_ch, 4);
    chk("R9 irq", err_irq, 1);
    release_gnt();
    clear_err();
    chk("R8 cleared valid", err_valid, 0);
    chk("R8 cleared prio", err_prio, 0);
    chk("R9 irq low", err_irq, 0);
  endtask

  task automatic t_idle_dup();
    repeat (4) @(negedge clk);
    chk("R3 no grant", gnt_valid, 0);
    chk("R3 no error", err_valid, 0);
  endtask

  task automatic t_hold();
    levels_up();
    grant(16'h0004);
    chk("R5 first", gnt_ch, 2);
    req = 16'h8004;
    lvl[2] = 4'd0;
    lvl[0] = 4'd2;
    repeat (3) @(negedge clk);
    chk("R5 held valid", gnt_valid, 1);
    chk("R5 held ch", gnt_ch, 2);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    chk("R5 drop", gnt_valid, 0);
    @(negedge clk);
    chk("R5 rearb", gnt_ch, 15);
    release_gnt();
    levels_up();
  endtask

  task automatic t_desc();
    levels_up();
    desc_bad[6] = 1'b1;
    grant(16'h0040);
    chk("R6 err valid", err_valid, 1);
    chk("R6 err ch", err_ch, 6);
    chk("R6 prio kept", err_prio, 0);
    release_gnt();
    clear_err();
    chk("R8 clear", err_valid, 0);
    grant(16'h0040);
    chk("R7 again", err_valid, 1);
    chk("R7 ch", err_ch, 6);
    release_gnt();
    desc_bad[6] = 1'b0;
    desc_bad[9] = 1'b1;
    req = 16'h0200;
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R8 new wins", err_valid, 1);
    chk("R8 new ch", err_ch, 9);
    release_gnt();
    desc_bad = '0;
    clear_err();
  endtask

  initial begin
    levels_up();
    lvl[3] = 4'd5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_highest();
    t_tie();
    levels_up();
    lvl[1] = 4'd8;
    t_idle_dup();
    t_hold();
    t_desc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule